// File: doc/BRIEF.md
# Pixel-to-Bus Cycle Serializer

This block takes display pixels of 12, 16, 18 or 24 bits from a ready/valid stream and cuts each one into one or more words for a parallel panel bus of 8, 9, 12 or 16 data lines. Its output is a ready/valid word stream toward the bus cycle timer. The timer owns the strobe timing, so this block only decides the content and the order of the words.

A controller programs the pixel width code, the bus width code, the cycle format and a pixel total, usually width times height, and then pulses `start`. The block captures that setting and keeps it for the whole frame. It consumes exactly the programmed number of pixels and always emits the most significant slice first. Besides the whole ratios of one, two or three words per pixel, it packs two pixels into three words. When the last word of the last pixel has been accepted, `active` falls and `frameDone` pulses.

Top module: `pixel_serializer`

## Requirements
- R1: The pixel width code `dataType` maps 0 to 12 bits, 1 to 16, 2 to 18 and 3 to 24. Pixel bits above the selected width are ignored, so the pixel enters the slicing as if those bits were zero.
- R2: The bus width code `busWidth` maps 0 to 8 lines, 1 to 9, 2 to 12 and 3 to 16. A word uses the low L bits of `wordData`, and every bit from L upward reads zero while `wordValid` is high.
- R3: For the cycle format codes 0, 1 and 2, each pixel gives 1, 2 or 3 words, highest slice first. Word i of a k-word pixel is pixel bits [(k-i)*L-1 : (k-1-i)*L]. For example, a 16-bit pixel on 8 lines is sent as bits 15:8 and then 7:0, and a 24-bit pixel on 8 lines as bits 23:16, 15:8 and 7:0.
- R4: Cycle format code 3 applies where 2*P = 3*L, with L even. Each pixel pair A, B gives three words: the upper L bits of A; then the lower L/2 bits of A in the upper half of the word with the upper L/2 bits of B in the lower half; then the lower L bits of B.
- R5: In format 3, an odd pixel total leaves the final pixel without a partner. That pixel gives only two words, and the partner half of the second word is zero.
- R6: A pulse on `start` while `active` is low captures `dataType`, `busWidth`, `cycleFmt` and `pixelTotal`. Changes to these inputs during a frame, and further `start` pulses during a frame, have no effect on that frame.
- R7: A frame accepts exactly `pixelTotal` pixels, and `pixReady` stays low once they have all been taken.
- R8: While `wordValid` is high and `wordReady` is low, the word and its valid are held unchanged. No slice is lost or repeated.
- R9: In the cycle after the edge that accepts the final word, `frameDone` is high for one cycle and `active` is low.
- R10: A `start` with `pixelTotal` equal to zero produces no words and raises `frameDone` in the cycle after the start edge.
- R11: After reset, `active`, `pixReady`, `wordValid` and `frameDone` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a frame when idle |
| dataType | input | 2 | Pixel width code |
| busWidth | input | 2 | Bus line count code |
| cycleFmt | input | 2 | Words-per-pixel format code |
| pixelTotal | input | CNT_W | Pixels in the frame |
| pixValid | input | 1 | Pixel offered |
| pixData | input | 24 | Pixel value, LSB aligned |
| pixReady | output | 1 | Pixel can be taken |
| wordValid | output | 1 | Bus word offered |
| wordData | output | 16 | Bus word, LSB aligned |
| wordReady | input | 1 | Bus timer takes the word |
| active | output | 1 | Frame in progress |
| frameDone | output | 1 | One-cycle end-of-frame pulse |

## Verification
Some properties are checked by assertions on every cycle. These are that a stalled word is held stable, that lines above the bus width stay zero, that nothing is offered or requested while idle, and that `active` only falls together with a `frameDone` pulse. The bench has to show the rest. Slice order, the packing of pixel pairs into three words, the zero padding of an unpaired last pixel, the masking of high pixel bits and the exact pixel count are all matched word by word against arithmetically derived expectations. Each valid pairing of pixel width and bus width is run with several totals and several stall patterns.

// File: rtl/pixser_pkg.sv
package pixser_pkg;
  localparam int PIX_W = 24;
  localparam int BUS_W = 16;

  typedef enum logic [1:0] {
    FMT_1   = 2'd0,
    FMT_2   = 2'd1,
    FMT_3   = 2'd2,
    FMT_3_2 = 2'd3
  } fmt_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       loadA;
    logic       loadB;
    logic       clrB;
    logic [1:0] idx;
  } dpCtrl_t;

  function automatic int unsigned lineCount(input logic [1:0] code);
    case (code)
      2'd0:    return 8;
      2'd1:    return 9;
      2'd2:    return 12;
      default: return 16;
    endcase
  endfunction

  function automatic int unsigned pixBits(input logic [1:0] code);
    case (code)
      2'd0:    return 12;
      2'd1:    return 16;
      2'd2:    return 18;
      default: return 24;
    endcase
  endfunction
endpackage

// File: rtl/pixser_datapath.sv
module pixser_datapath
  import pixser_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrl_t          ctl,
  input  logic [1:0]       dtCode,
  input  logic [1:0]       busCode,
  input  fmt_e             fmt,
  input  logic [PIX_W-1:0] pixIn,
  output logic [BUS_W-1:0] word
);
  logic [PIX_W-1:0] pixA, pixB, pixMasked, wide, halfMask;
  logic [BUS_W-1:0] laneMask;
  int unsigned lines, half;
  int shiftAmt;

  always_comb begin
    pixMasked = pixIn & PIX_W'((32'd1 << pixBits(dtCode)) - 32'd1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixA <= '0;
      pixB <= '0;
    end else begin
      if (ctl.loadA) pixA <= pixMasked;
      if (ctl.loadB) pixB <= pixMasked;
      else if (ctl.clrB) pixB <= '0;
    end
  end

  always_comb begin
    lines    = lineCount(busCode);
    half     = lines / 2;
    laneMask = BUS_W'((32'd1 << lines) - 32'd1);
    halfMask = PIX_W'((32'd1 << half) - 32'd1);
    shiftAmt = 0;
    if (fmt == FMT_3_2) begin
      case (ctl.idx)
        2'd0:    wide = pixA >> half;
        2'd1:    wide = ((pixA & halfMask) << half) | (pixB >> lines);
        default: wide = pixB;
      endcase
    end else begin
      if (int'(fmt) > int'(ctl.idx))
        shiftAmt = (int'(fmt) - int'(ctl.idx)) * int'(lines);
      wide = pixA >> shiftAmt;
    end
    word = wide[BUS_W-1:0] & laneMask;
  end
endmodule

// File: rtl/pixser_control.sv
module pixser_control
  import pixser_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [1:0]       dataType,
  input  logic [1:0]       busWidth,
  input  logic [1:0]       cycleFmt,
  input  logic [CNT_W-1:0] pixelTotal,
  input  logic             pixValid,
  input  logic             wordReady,
  output logic             pixReady,
  output logic             wordValid,
  output logic             active,
  output logic             frameDone,
  output logic [1:0]       dtQ,
  output logic [1:0]       busQ,
  output fmt_e             fmtQ,
  output dpCtrl_t          ctl
);
  logic             activeQ, haveQ, padQ, doneQ;
  logic [1:0]       idxQ;
  logic [CNT_W-1:0] inCnt, totalQ;
  logic             pixFire, wordFire, lastStep, moreLeft, pairMode;

  assign moreLeft  = inCnt != totalQ;
  assign pairMode  = fmtQ == FMT_3_2;
  assign pixReady  = activeQ && !haveQ && moreLeft;
  assign wordValid = activeQ && haveQ;
  assign pixFire   = pixReady && pixValid;
  assign wordFire  = wordValid && wordReady;
  assign active    = activeQ;
  assign frameDone = doneQ;

  always_comb begin
    if (pairMode) lastStep = (idxQ == 2'd2) || (idxQ == 2'd1 && padQ);
    else          lastStep = idxQ == 2'(fmtQ);
    ctl.loadA = pixFire && idxQ == 2'd0;
    ctl.loadB = pixFire && idxQ != 2'd0;
    ctl.clrB  = wordFire && pairMode && idxQ == 2'd0 && !moreLeft;
    ctl.idx   = idxQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      haveQ   <= 1'b0;
      padQ    <= 1'b0;
      doneQ   <= 1'b0;
      idxQ    <= '0;
      inCnt   <= '0;
      totalQ  <= '0;
      dtQ     <= '0;
      busQ    <= '0;
      fmtQ    <= FMT_1;
    end else begin
      doneQ <= 1'b0;
      if (!activeQ) begin
        if (start) begin
          dtQ    <= dataType;
          busQ   <= busWidth;
          fmtQ   <= fmt_e'(cycleFmt);
          totalQ <= pixelTotal;
          inCnt  <= '0;
          idxQ   <= '0;
          haveQ  <= 1'b0;
          padQ   <= 1'b0;
          if (pixelTotal == '0) doneQ <= 1'b1;
          else activeQ <= 1'b1;
        end
      end else begin
        if (pixFire) begin
          haveQ <= 1'b1;
          inCnt <= inCnt + 1'b1;
        end
        if (wordFire) begin
          if (lastStep) begin
            idxQ  <= '0;
            haveQ <= 1'b0;
            padQ  <= 1'b0;
            if (!moreLeft) begin
              activeQ <= 1'b0;
              doneQ   <= 1'b1;
            end
          end else begin
            idxQ <= idxQ + 2'd1;
            if (pairMode && idxQ == 2'd0) begin
              if (moreLeft) haveQ <= 1'b0;
              else padQ <= 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/pixel_serializer.sv
module pixel_serializer
  import pixser_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [1:0]       dataType,
  input  logic [1:0]       busWidth,
  input  logic [1:0]       cycleFmt,
  input  logic [CNT_W-1:0] pixelTotal,
  input  logic             pixValid,
  input  logic [PIX_W-1:0] pixData,
  output logic             pixReady,
  output logic             wordValid,
  output logic [BUS_W-1:0] wordData,
  input  logic             wordReady,
  output logic             active,
  output logic             frameDone
);
  dpCtrl_t    ctl;
  logic [1:0] dtQ, busQ;
  fmt_e       fmtQ;

  pixser_control #(.CNT_W(CNT_W)) i_control (
    .clk(clk), .rstN(rstN), .start(start),
    .dataType(dataType), .busWidth(busWidth), .cycleFmt(cycleFmt),
    .pixelTotal(pixelTotal), .pixValid(pixValid), .wordReady(wordReady),
    .pixReady(pixReady), .wordValid(wordValid), .active(active),
    .frameDone(frameDone), .dtQ(dtQ), .busQ(busQ), .fmtQ(fmtQ), .ctl(ctl)
  );

  pixser_datapath i_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .dtCode(dtQ), .busCode(busQ),
    .fmt(fmtQ), .pixIn(pixData), .word(wordData)
  );
endmodule

// File: rtl/pixser_checker.sv
module pixser_checker
  import pixser_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             active,
  input logic             frameDone,
  input logic             pixReady,
  input logic             wordValid,
  input logic             wordReady,
  input logic [BUS_W-1:0] wordData,
  input logic [1:0]       busQ
);
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    wordValid && !wordReady |=> wordValid && $stable(wordData)); // R8

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> (32'(wordData) >> lineCount(busQ)) == 32'd0); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !active |-> !pixReady && !wordValid); // R11

  AST_END_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(active) |-> frameDone); // R9

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> !active); // R9
endmodule

bind pixel_serializer pixser_checker i_checker (
  .clk(clk), .rstN(rstN), .active(active), .frameDone(frameDone),
  .pixReady(pixReady), .wordValid(wordValid), .wordReady(wordReady),
  .wordData(wordData), .busQ(busQ)
);

// File: tb/test_pixel_serializer.sv
module test_pixel_serializer;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [1:0] dataType = '0, busWidth = '0, cycleFmt = '0;
  logic [CNT_W-1:0] pixelTotal = '0;
  logic pixValid = 1'b0;
  logic [23:0] pixData = '0;
  logic pixReady, wordValid, active, frameDone;
  logic [15:0] wordData;
  logic wordReady = 1'b0;

  int checks = 0;
  int fails = 0;
  logic [23:0] pix [0:7];
  logic [15:0] expW [0:31];

  always #(CLK_PERIOD/2) clk = ~clk;

  pixel_serializer #(.CNT_W(CNT_W)) i_pixel_serializer (
    .clk(clk), .rstN(rstN), .start(start), .dataType(dataType),
    .busWidth(busWidth), .cycleFmt(cycleFmt), .pixelTotal(pixelTotal),
    .pixValid(pixValid), .pixData(pixData), .pixReady(pixReady),
    .wordValid(wordValid), .wordData(wordData), .wordReady(wordReady),
    .active(active), .frameDone(frameDone)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  function automatic int lc(input int c);
    return (c == 0) ? 8 : (c == 1) ? 9 : (c == 2) ? 12 : 16;
  endfunction

  function automatic int pb(input int c);
    return (c == 0) ? 12 : (c == 1) ? 16 : (c == 2) ? 18 : 24;
  endfunction

  function automatic longint msk(input int n);
    return (64'd1 << n) - 64'd1;
  endfunction

  task automatic runFrame(input int dt, input int bw, input int fmt, input int total, input int seed);
    int lines, bits, nW, inIdx, outIdx, cyc;
    bit seen, overTake;
    longint a, b;
    string tag;
    lines = lc(bw);
    bits = pb(dt);
    nW = 0;
    for (int i = 0; i < 8; i++)
      pix[i] = 24'(32'hA5C3F1 ^ (i * 32'h13579B) ^ (seed * 32'h2468AC) ^ (dt * 32'h0F0F0F));
    if (fmt < 3) begin
      for (int i = 0; i < total; i++) begin
        a = longint'(pix[i]) & msk(bits);
        for (int s = fmt; s >= 0; s--) begin
          expW[nW] = 16'((a >> (s * lines)) & msk(lines));
          nW++;
        end
      end
    end else begin
      for (int i = 0; i < total; i += 2) begin
        a = longint'(pix[i]) & msk(bits);
        b = (i + 1 < total) ? (longint'(pix[i+1]) & msk(bits)) : 64'd0;
        expW[nW] = 16'((a >> (bits - lines)) & msk(lines));
        expW[nW+1] = 16'((((a & msk(bits - lines)) << (2 * lines - bits)) |
                          (b >> (2 * bits - 2 * lines))) & msk(lines));
        nW += 2;
        if (i + 1 < total) begin
          expW[nW] = 16'(b & msk(lines));
          nW++;
        end
      end
    end

    @(negedge clk);
    dataType = 2'(dt);
    busWidth = 2'(bw);
    cycleFmt = 2'(fmt);
    pixelTotal = CNT_W'(total);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    dataType = ~dataType;
    busWidth = ~busWidth;
    cycleFmt = ~cycleFmt;
    pixelTotal = CNT_W'(total + 3);
    inIdx = 0;
    outIdx = 0;
    seen = 1'b0;
    overTake = 1'b0;
    for (cyc = 0; cyc < 3000; cyc++) begin
      if (frameDone) begin
        tag = (total == 0) ? "R10" : "R6 R7 R9";
        check(outIdx == nW && inIdx == total && !active, tag, outIdx, nW);
        seen = 1'b1;
        break;
      end
      start = (cyc == 2);
      wordReady = (seed == 0) || (((cyc * seed + 1) % 3) != 0);
      if (wordValid && wordReady) begin
        if (fmt < 3) tag = "R3 R1 R2 R8";
        else if ((total % 2 == 1) && outIdx >= nW - 2) tag = "R5 R1 R2 R8";
        else tag = "R4 R1 R2 R8";
        if (outIdx < nW) check(wordData == expW[outIdx], tag, wordData, expW[outIdx]);
        else check(1'b0, "R6 R7 extra word", outIdx, nW);
        outIdx++;
      end
      pixValid = (inIdx < total) && ((seed < 2) || ((cyc % 4) != 1));
      pixData = (inIdx < total) ? pix[inIdx] : 24'hFFFFFF;
      if (inIdx >= total && pixReady) overTake = 1'b1;
      if (pixValid && pixReady) inIdx++;
      @(negedge clk);
    end
    start = 1'b0;
    pixValid = 1'b0;
    wordReady = 1'b0;
    check(seen, "R9 frameDone seen", seen, 1);
    check(!overTake, "R7 pixReady after last pixel", overTake, 0);
    @(negedge clk);
    check(!frameDone && !active, "R9 single-cycle pulse", frameDone, 0);
  endtask

  initial begin
    int totals [5] = '{0, 1, 2, 3, 5};
    repeat (3) @(negedge clk);
    check(!active && !pixReady && !wordValid && !frameDone, "R11 reset state",
          {active, pixReady, wordValid, frameDone}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!active && !pixReady && !wordValid && !frameDone, "R11 after reset",
          {active, pixReady, wordValid, frameDone}, 0);
    for (int dt = 0; dt < 4; dt++) begin
      for (int bw = 0; bw < 4; bw++) begin
        int p, l, f;
        p = pb(dt);
        l = lc(bw);
        f = -1;
        if (p % l == 0 && p / l >= 1 && p / l <= 3) f = p / l - 1;
        else if ((2 * p) % l == 0 && (2 * p) / l == 3) f = 3;
        if (f >= 0) begin
          for (int t = 0; t < 5; t++)
            for (int s = 0; s < 3; s++)
              runFrame(dt, bw, f, totals[t], s);
        end
      end
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule